// File: doc/BRIEF.md
# SPI Serial Memory Slave Front End

This block is the serial side of a memory device attached over SPI. It receives chip-select (active low), the serial clock, the serial data input and an active-low pause input. It drives a serial data output together with an output enable, so that the pad can be tri-stated. Incoming bits are gathered into bytes and handed to the parallel side with a one-cycle strobe. Bytes that the parallel side presents are shifted out most significant bit first. The block does not decode commands and holds no storage array. Only SPI mode 0 timing is supported: the clock idles low, input data is sampled on the rising edge and output data moves after the falling edge.

All four serial inputs pass through a synchroniser into a faster system clock, and edges are found in that domain. The block tracks whether it is selected and whether it is paused. A pause freezes the bit counter and both shift registers, so a transfer carries on where it stopped. After reset, a session that was already open is refused: the block waits for a fresh falling edge on chip-select.

Top module: `spi_mem_frontend`

## Requirements
- R1: While chip-select is high, `so_oe_o` is 0 and the block counts as deselected.
- R2: If chip-select is low when reset ends, that session is ignored: no byte strobe is produced and `so_oe_o` stays 0 until chip-select has gone high and then low again.
- R3: SI is sampled on each rising SCK edge, most significant bit first. After every eighth sampled bit, `rx_valid_o` is high for exactly one system clock and `rx_byte_o` holds the assembled byte.
- R4: At selection and after every eighth bit, the block captures `tx_byte_i` and pulses `tx_load_o` for one clock. Bit 7 of the captured byte drives SO first. SO moves to the next lower bit only after a falling SCK edge and holds steady while SCK is high.
- R5: Raising chip-select clears the bit counter. A partial byte is discarded without a strobe, and the next session starts on a byte boundary.
- R6: When HOLD is taken low while SCK is low, the block pauses. SCK and SI activity is ignored during the pause, and the partial bit count and the shift contents are kept.
- R7: When HOLD falls while SCK is high, the pause starts at the next falling SCK edge. That edge still advances SO.
- R8: A pause ends only when HOLD rises while SCK is low. If HOLD is released while SCK is high, the block stays paused.
- R9: Whenever the HOLD input is low, `so_oe_o` is 0 in the same instant, whatever the SCK phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock from the host |
| si_i | input | 1 | Serial data from the host |
| hold_n_i | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data to the host |
| so_oe_o | output | 1 | Output enable for SO; 0 means high impedance |
| rx_byte_o | output | DATA_W | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe that marks a new received byte |
| tx_byte_i | input | DATA_W | Next byte to send |
| tx_load_o | output | 1 | One-cycle strobe: `tx_byte_i` has been taken |

## Verification
The assertions assume that SCK, SI and HOLD stay stable for several system clocks between changes. Under that assumption every synchronised edge is seen on its own, and two rising SCK edges can never give back-to-back byte strobes. The bench drives each SPI phase for eight system clocks and spaces each HOLD change and each garbage SCK toggle four clocks apart. Chip-select changes only while SCK is low, which keeps every transaction within mode 0.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    // bit positions inside the synchroniser vector
    localparam int SYN_CS   = 0;
    localparam int SYN_SCK  = 1;
    localparam int SYN_SI   = 2;
    localparam int SYN_HOLD = 3;
    localparam int SYN_W    = 4;

    typedef struct packed {
        logic sel;        // session accepted after a select edge
        logic paused;     // pause in force
        logic oe;         // registered part of the SO enable
        logic cs_prev;
        logic sck_prev;
        logic hold_prev;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{
        sel: 1'b0, paused: 1'b0, oe: 1'b0,
        cs_prev: 1'b0, sck_prev: 1'b0, hold_prev: 1'b0
    };

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                assign chain_d[g] = async_i;
            end else begin : g_next
                assign chain_d[g] = chain_q[g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
    import spi_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_cs_n,
    input  logic s_sck,
    input  logic s_hold_n,
    output logic sel_o,
    output logic paused_o,
    output logic oe_o,
    output logic start_o,
    output logic rise_en_o,
    output logic fall_en_o
);
    ctrl_state_t st_d, st_q;
    logic cs_fall, sck_rise, sck_fall, hold_rise, live;

    always_comb begin
        st_d      = st_q;
        cs_fall   = st_q.cs_prev && !s_cs_n;
        sck_rise  = !st_q.sck_prev && s_sck;
        sck_fall  = st_q.sck_prev && !s_sck;
        hold_rise = !st_q.hold_prev && s_hold_n;

        st_d.cs_prev   = s_cs_n;
        st_d.sck_prev  = s_sck;
        st_d.hold_prev = s_hold_n;

        // selection needs a fresh falling edge of chip-select
        if (s_cs_n)       st_d.sel = 1'b0;
        else if (cs_fall) st_d.sel = 1'b1;

        // pause: enter on HOLD low with SCK low, leave on HOLD rise with SCK low
        if (!st_d.sel) begin
            st_d.paused = 1'b0;
        end else if (!st_q.paused) begin
            if (!s_hold_n && !s_sck) st_d.paused = 1'b1;
        end else if (hold_rise && !s_sck) begin
            st_d.paused = 1'b0;
        end

        st_d.oe = st_d.sel && !st_d.paused;

        live      = st_q.sel && !s_cs_n && !st_q.paused;
        start_o   = cs_fall;
        rise_en_o = live && s_hold_n && sck_rise;
        fall_en_o = live && sck_fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTRL_RESET;
        else        st_q <= st_d;
    end

    assign sel_o    = st_q.sel;
    assign paused_o = st_q.paused;
    assign oe_o     = st_q.oe;
endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_i,
    input  logic                 start_i,
    input  logic                 rise_en_i,
    input  logic                 fall_en_i,
    input  logic                 si_i,
    input  logic [W-1:0]         tx_byte_i,
    output logic [W-1:0]         rx_byte_o,
    output logic                 rx_valid_o,
    output logic                 so_o,
    output logic                 tx_load_o,
    output logic [$clog2(W)-1:0] cnt_o
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic [W-1:0]  rx_sr;
        logic [W-1:0]  tx_sr;
        logic [W-1:0]  rx_byte;
        logic [CW-1:0] cnt;
        logic          rx_valid;
        logic          tx_load;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [W-1:0] rx_next;

    always_comb begin
        st_d          = st_q;
        st_d.rx_valid = 1'b0;
        st_d.tx_load  = 1'b0;
        rx_next       = {st_q.rx_sr[W-2:0], si_i};

        if (!sel_i) begin
            st_d.cnt   = '0;
            st_d.rx_sr = '0;
        end

        if (start_i) begin
            st_d.tx_sr   = tx_byte_i;
            st_d.tx_load = 1'b1;
            st_d.cnt     = '0;
        end else if (rise_en_i) begin
            st_d.rx_sr = rx_next;
            if (st_q.cnt == LAST) begin
                st_d.cnt      = '0;
                st_d.rx_byte  = rx_next;
                st_d.rx_valid = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (fall_en_i) begin
            if (st_q.cnt == '0) begin
                st_d.tx_sr   = tx_byte_i;
                st_d.tx_load = 1'b1;
            end else begin
                st_d.tx_sr = {st_q.tx_sr[W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rx_byte_o  = st_q.rx_byte;
    assign rx_valid_o = st_q.rx_valid;
    assign so_o       = st_q.tx_sr[W-1];
    assign tx_load_o  = st_q.tx_load;
    assign cnt_o      = st_q.cnt;
endmodule

// File: rtl/spi_mem_frontend.sv
module spi_mem_frontend
    import spi_fe_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              sck_i,
    input  logic              si_i,
    input  logic              hold_n_i,
    output logic              so_o,
    output logic              so_oe_o,
    output logic [DATA_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    input  logic [DATA_W-1:0] tx_byte_i,
    output logic              tx_load_o
);
    localparam int CW = $clog2(DATA_W);

    logic [SYN_W-1:0] raw_w, syn_w;
    logic sel_w, paused_w, oe_w, start_w, rise_en_w, fall_en_w;
    logic [CW-1:0] cnt_w;

    always_comb begin
        raw_w           = '0;
        raw_w[SYN_CS]   = cs_n_i;
        raw_w[SYN_SCK]  = sck_i;
        raw_w[SYN_SI]   = si_i;
        raw_w[SYN_HOLD] = hold_n_i;
    end

    spi_fe_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_w),
        .sync_o  (syn_w)
    );

    spi_fe_ctrl i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_cs_n    (syn_w[SYN_CS]),
        .s_sck     (syn_w[SYN_SCK]),
        .s_hold_n  (syn_w[SYN_HOLD]),
        .sel_o     (sel_w),
        .paused_o  (paused_w),
        .oe_o      (oe_w),
        .start_o   (start_w),
        .rise_en_o (rise_en_w),
        .fall_en_o (fall_en_w)
    );

    spi_fe_shift #(.W(DATA_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (sel_w),
        .start_i    (start_w),
        .rise_en_i  (rise_en_w),
        .fall_en_i  (fall_en_w),
        .si_i       (syn_w[SYN_SI]),
        .tx_byte_i  (tx_byte_i),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o),
        .so_o       (so_o),
        .tx_load_o  (tx_load_o),
        .cnt_o      (cnt_w)
    );

    // raw HOLD and chip-select cut the driver at once, without waiting for sync
    assign so_oe_o = oe_w & hold_n_i & ~cs_n_i;
endmodule

// File: rtl/spi_fe_checker.sv
module spi_fe_checker #(
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n_i,
    input logic          hold_n_i,
    input logic          so_o,
    input logic          so_oe_o,
    input logic          rx_valid_o,
    input logic          sel,
    input logic          paused,
    input logic          fall_en,
    input logic          start,
    input logic [CW-1:0] cnt
);
    assert_deselect_tristate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_i |-> !so_oe_o);

    assert_rx_needs_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> $past(sel));

    assert_rx_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_so_moves_after_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(so_o) |-> $past(fall_en || start));

    assert_count_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sel) |-> cnt == '0);

    assert_pause_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && $past(paused)) |-> ($stable(cnt) && $stable(so_o)));

    assert_hold_tristate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_n_i |-> !so_oe_o);
endmodule

bind spi_mem_frontend spi_fe_checker #(.CW(CW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n_i     (cs_n_i),
    .hold_n_i   (hold_n_i),
    .so_o       (so_o),
    .so_oe_o    (so_oe_o),
    .rx_valid_o (rx_valid_o),
    .sel        (sel_w),
    .paused     (paused_w),
    .fall_en    (fall_en_w),
    .start      (start_w),
    .cnt        (cnt_w)
);

// File: tb/test_spi_mem_frontend.sv
module test_spi_mem_frontend;
    localparam int HALF = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic [7:0] tx_byte, rx_byte;
    logic so, so_oe, rx_valid, tx_load;

    int checks = 0, failures = 0;
    int idx = 0, rx_total = 0;
    logic [7:0] rx_buf [256];
    bit finished = 0;

    always #5 clk = ~clk;

    spi_mem_frontend i_spi_mem_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sck_i(sck), .si_i(si),
        .hold_n_i(hold_n), .so_o(so), .so_oe_o(so_oe), .rx_byte_o(rx_byte),
        .rx_valid_o(rx_valid), .tx_byte_i(tx_byte), .tx_load_o(tx_load)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) ^ (i / 4));
    endfunction

    assign tx_byte = pat(idx);

    // parallel-side model: advance on each load, log each received byte
    always @(posedge clk) begin
        if (tx_load) idx <= idx + 1;
        if (rx_valid) begin
            rx_buf[rx_total % 256] <= rx_byte;
            rx_total <= rx_total + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic garbage_toggle();
        si = 1'($urandom); sck = 1'b1; wait_clk(4);
        si = 1'($urandom); sck = 1'b0; wait_clk(4);
    endtask

    // pause entered and left with SCK low (R6, R9)
    task automatic pause_low(input logic keep_bit);
        hold_n = 1'b0; wait_clk(4);
        check(so_oe == 1'b0, "R9", "oe with HOLD low", so_oe, 0);
        garbage_toggle();
        garbage_toggle();
        check(so_oe == 1'b0, "R6", "oe while paused", so_oe, 0);
        si = keep_bit; wait_clk(2);
        hold_n = 1'b1; wait_clk(4);
    endtask

    // HOLD falls with SCK high (R7), optionally released with SCK high (R8)
    task automatic pause_high(input bit release_high);
        hold_n = 1'b0; wait_clk(4);
        check(so_oe == 1'b0, "R9", "oe with HOLD low, SCK high", so_oe, 0);
        sck = 1'b0; wait_clk(4);
        garbage_toggle();
        if (release_high) begin
            sck = 1'b1; wait_clk(4);
            hold_n = 1'b1; wait_clk(4);
            sck = 1'b0; wait_clk(4);
            check(so_oe == 1'b0, "R8", "oe after release with SCK high", so_oe, 0);
            garbage_toggle();
            hold_n = 1'b0; wait_clk(4);
        end
        check(so_oe == 1'b0, "R7", "oe while paused", so_oe, 0);
        hold_n = 1'b1; wait_clk(4);
    endtask

    task automatic xfer_byte(input logic [7:0] mosi, input int pmode, input int pbit,
                             output logic [7:0] miso, output bit oe_all,
                             output bit oe_any, output bit steady);
        oe_all = 1; oe_any = 0; steady = 1; miso = '0;
        for (int b = 7; b >= 0; b--) begin
            si = mosi[b]; wait_clk(HALF);
            if (pmode == 1 && pbit == b) pause_low(mosi[b]);
            miso[b] = so;
            if (so_oe !== 1'b1) oe_all = 0;
            if (so_oe === 1'b1) oe_any = 1;
            sck = 1'b1; wait_clk(HALF / 2);
            if (so !== miso[b]) steady = 0;
            wait_clk(HALF / 2);
            if (pmode >= 2 && pbit == b) pause_high(pmode == 3);
            else sck = 1'b0;
        end
    endtask

    task automatic run_session(input int n, input int force_mode, input int force_bit,
                               input string plain_tag);
        logic [7:0] mosi [8];
        int modes [8];
        logic [7:0] miso;
        int base, rx0, pm, pb;
        bit oe_all, oe_any, steady;
        string tag;
        cs_n = 1'b0; base = idx; rx0 = rx_total;
        wait_clk(HALF);
        for (int j = 0; j < n; j++) begin
            mosi[j] = 8'($urandom);
            if (force_mode >= 0) begin
                pm = (j == 0) ? force_mode : 0; pb = force_bit;
            end else begin
                pm = int'($urandom % 4); pb = int'($urandom % 8);
            end
            modes[j] = pm;
            xfer_byte(mosi[j], pm, pb, miso, oe_all, oe_any, steady);
            check(miso == pat(base + j), "R4", "SO byte", miso, pat(base + j));
            check(oe_all && steady, "R4", "SO driven and steady in high phase",
                  {oe_all, steady}, 3);
        end
        wait_clk(HALF);
        check(rx_total - rx0 == n, "R3", "byte strobe count", rx_total - rx0, n);
        for (int j = 0; j < n; j++) begin
            case (modes[j])
                1: tag = "R6";
                2: tag = "R7";
                3: tag = "R8";
                default: tag = plain_tag;
            endcase
            check(rx_buf[(rx0 + j) % 256] == mosi[j], tag, "received byte",
                  rx_buf[(rx0 + j) % 256], mosi[j]);
        end
        cs_n = 1'b1; wait_clk(HALF);
        check(so_oe == 1'b0, "R1", "oe after deselect", so_oe, 0);
    endtask

    initial begin
        logic [7:0] miso;
        bit oe_all, oe_any, steady;
        int rx0;
        void'($urandom(32'd4242));
        // chip-select already low through reset (R2)
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        check(rx_valid == 1'b0, "R2", "strobe after reset", rx_valid, 0);
        check(so_oe == 1'b0, "R2", "oe after reset with CS low", so_oe, 0);
        xfer_byte(8'hA5, 0, 0, miso, oe_all, oe_any, steady);
        wait_clk(HALF);
        check(rx_total == 0, "R2", "bytes from stale session", rx_total, 0);
        check(oe_any == 1'b0, "R2", "SO driven in stale session", oe_any, 0);
        cs_n = 1'b1; wait_clk(HALF);
        check(so_oe == 1'b0, "R1", "oe while deselected", so_oe, 0);

        run_session(2, 0, 0, "R3");

        // partial byte then a new session (R5)
        cs_n = 1'b0; rx0 = rx_total; wait_clk(HALF);
        for (int b = 0; b < 5; b++) begin
            si = 1'($urandom); wait_clk(HALF);
            sck = 1'b1; wait_clk(HALF);
            sck = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1; wait_clk(HALF);
        check(rx_total == rx0, "R5", "strobe from partial byte", rx_total - rx0, 0);
        run_session(1, 0, 0, "R5");

        run_session(2, 1, 3, "R3");
        run_session(2, 2, 0, "R3");
        run_session(2, 2, 7, "R3");
        run_session(2, 3, 5, "R3");
        run_session(1, 1, 7, "R3");

        for (int s = 0; s < 8; s++) run_session(1 + int'($urandom % 4), -1, 0, "R3");

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1;
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule